// File: doc/BRIEF.md
# PHY Reset and PLL-Lock Sequencer

This controller takes a serial PHY out of reset after power-up. It does not drive the PHY's internal register port itself. Instead it issues one command at a time to a separate handshake master, which performs the capture, read and write strobes and reports the result. After a start request and a fixed settling delay, the sequencer selects the PHY clock/reset register and writes the reset request into it. The write command it uses tells the handshake master not to wait for a write acknowledge, because a PHY that is resetting cannot give one.

Once the reset is written, the sequencer runs a bounded poll. Each round waits a programmable gap, selects the lane-0 output status register and reads it. It stops as soon as the receive-PLL stable bit is set. The run ends with a one-cycle done pulse and exactly one of three held verdict flags: locked, poll exhausted, or handshake failure.

Top module: `phy_rst_seq`

## Requirements
- R1: After reset, cmd_valid_o, done_o, pass_o, poll_timeout_o and hs_fail_o are all low.
- R2: The first command appears on cmd_valid_o exactly PRE_CYCLES+1 clock cycles after the cycle in which start_i is sampled high while idle.
- R3: The first command is an address select (cmd_op_o = 0) with cmd_data_o = 0x7F3F. The second command carries cmd_data_o = RST_VAL (0x0001). Because bit 0 of that value is set, it uses the write-without-acknowledge op (cmd_op_o = 2) rather than the plain write (cmd_op_o = 1).
- R4: Each poll round first waits: its address command appears exactly POLL_CYCLES+1 cycles after the response to the previous command (the reset write or a failed read). The round then issues an address select (op 0) of 0x2003, followed by a read (op 3).
- R5: A command is issued only after the response to the previous one. cmd_valid_o is high for a single cycle per command.
- R6: A read response with bit 1 of rsp_data_i set ends the run with pass_o, and no further command is issued. All other bits of rsp_data_i have no effect.
- R7: If MAX_TRIES reads all return bit 1 clear, the run ends with poll_timeout_o after exactly 2+2*MAX_TRIES commands.
- R8: A response with rsp_err_i set, on any command, ends the run at once with hs_fail_o, and no further command is issued.
- R9: A start_i pulse while a run is in progress has no effect on the command sequence or on the number of done pulses.
- R10: done_o is a one-cycle pulse, one cycle after the final response. At that point exactly one verdict flag is high. The flags hold their value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to run the sequence (sampled while idle) |
| cmd_valid_o | output | 1 | One-cycle command issue to the handshake master |
| cmd_op_o | output | 2 | 0 address, 1 write, 2 write without ack, 3 read |
| cmd_data_o | output | 16 | Register address or write value |
| rsp_valid_i | input | 1 | Handshake master finished the command |
| rsp_err_i | input | 1 | Handshake master timed out on the command |
| rsp_data_i | input | 16 | Read data, valid with rsp_valid_i |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| pass_o | output | 1 | Receive PLL reported stable |
| poll_timeout_o | output | 1 | Poll limit reached without lock |
| hs_fail_o | output | 1 | Sequence aborted on a handshake error |

## Verification
A wrong internal state shows up at the command port within one command. A wrong state order changes the next op or data value. A bad delay counter shifts the arrival cycle of the first or next address command, and the bench measures that cycle exactly. A miscounted try counter changes the total number of commands and the verdict flag seen with the done pulse. A broken abort path lets one extra command escape after the error response.

// File: rtl/phy_rst_seq_pkg.sv
package phy_rst_seq_pkg;

    typedef enum logic [1:0] {
        OP_ADDR        = 2'd0,
        OP_WRITE       = 2'd1,
        OP_WRITE_NOACK = 2'd2,
        OP_READ        = 2'd3
    } cr_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_ADDR_RST,
        S_WR_RST,
        S_POLL_WAIT,
        S_ADDR_STAT,
        S_RD_STAT
    } seq_state_e;

endpackage

// File: rtl/seq_delay.sv
module seq_delay #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    // R2 / R4: a counting delay only moves downward until reloaded
    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load_i) && $past(cnt_q) != '0) |-> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/phy_rst_seq.sv
module phy_rst_seq
    import phy_rst_seq_pkg::*;
#(
    parameter int          PRE_CYCLES  = 2000,
    parameter int          POLL_CYCLES = 15000,
    parameter int          MAX_TRIES   = 10,
    parameter int          DW          = 16,
    parameter logic [15:0] RST_REG     = 16'h7F3F,
    parameter logic [15:0] STAT_REG    = 16'h2003,
    parameter logic [15:0] RST_VAL     = 16'h0001,
    parameter int          LOCK_BIT    = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          cmd_valid_o,
    output logic [1:0]    cmd_op_o,
    output logic [DW-1:0] cmd_data_o,
    input  logic          rsp_valid_i,
    input  logic          rsp_err_i,
    input  logic [DW-1:0] rsp_data_i,
    output logic          done_o,
    output logic          pass_o,
    output logic          poll_timeout_o,
    output logic          hs_fail_o
);
    localparam int MAXD = (PRE_CYCLES > POLL_CYCLES) ? PRE_CYCLES : POLL_CYCLES;
    localparam int TW   = $clog2(MAXD + 1);
    localparam int TRW  = $clog2(MAX_TRIES + 1);
    localparam logic [TW-1:0]  PRE_LOAD  = TW'(PRE_CYCLES - 1);
    localparam logic [TW-1:0]  POLL_LOAD = TW'(POLL_CYCLES - 1);
    localparam logic [TRW-1:0] LAST_TRY  = TRW'(MAX_TRIES - 1);
    localparam cr_op_e         RST_OP    = RST_VAL[0] ? OP_WRITE_NOACK : OP_WRITE;

    typedef struct packed {
        seq_state_e     state;
        logic           sent;
        logic [TRW-1:0] tries;
        logic           done;
        logic           pass;
        logic           tmo;
        logic           fail;
    } seq_regs_t;

    seq_regs_t s_d, s_q;
    logic          tmr_load, tmr_exp, is_cmd;
    logic [TW-1:0] tmr_val;
    cr_op_e        op;
    logic [DW-1:0] data;

    seq_delay #(.W(TW)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tmr_load),
        .val_i    (tmr_val),
        .expired_o(tmr_exp)
    );

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        is_cmd      = 1'b0;
        op          = OP_ADDR;
        data        = '0;
        cmd_valid_o = 1'b0;

        case (s_q.state)
            S_IDLE: if (start_i) begin
                s_d.state = S_PRE;
                s_d.sent  = 1'b0;
                s_d.tries = '0;
                s_d.pass  = 1'b0;
                s_d.tmo   = 1'b0;
                s_d.fail  = 1'b0;
                tmr_load  = 1'b1;
                tmr_val   = PRE_LOAD;
            end
            S_PRE:       if (tmr_exp) s_d.state = S_ADDR_RST;
            S_POLL_WAIT: if (tmr_exp) s_d.state = S_ADDR_STAT;
            S_ADDR_RST:  begin is_cmd = 1'b1; op = OP_ADDR; data = DW'(RST_REG);  end
            S_WR_RST:    begin is_cmd = 1'b1; op = RST_OP;  data = DW'(RST_VAL);  end
            S_ADDR_STAT: begin is_cmd = 1'b1; op = OP_ADDR; data = DW'(STAT_REG); end
            S_RD_STAT:   begin is_cmd = 1'b1; op = OP_READ; data = '0;            end
            default:     s_d.state = S_IDLE;
        endcase

        if (is_cmd) begin
            cmd_valid_o = !s_q.sent;
            if (!s_q.sent) begin
                s_d.sent = 1'b1;
            end else if (rsp_valid_i) begin
                s_d.sent = 1'b0;
                if (rsp_err_i) begin
                    s_d.state = S_IDLE;
                    s_d.done  = 1'b1;
                    s_d.fail  = 1'b1;
                end else begin
                    case (s_q.state)
                        S_ADDR_RST:  s_d.state = S_WR_RST;
                        S_WR_RST: begin
                            s_d.state = S_POLL_WAIT;
                            tmr_load  = 1'b1;
                            tmr_val   = POLL_LOAD;
                        end
                        S_ADDR_STAT: s_d.state = S_RD_STAT;
                        default: begin
                            if (rsp_data_i[LOCK_BIT]) begin
                                s_d.state = S_IDLE;
                                s_d.done  = 1'b1;
                                s_d.pass  = 1'b1;
                            end else if (s_q.tries == LAST_TRY) begin
                                s_d.state = S_IDLE;
                                s_d.done  = 1'b1;
                                s_d.tmo   = 1'b1;
                            end else begin
                                s_d.tries = s_q.tries + 1'b1;
                                s_d.state = S_POLL_WAIT;
                                tmr_load  = 1'b1;
                                tmr_val   = POLL_LOAD;
                            end
                        end
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: S_IDLE, sent: 1'b0, tries: '0,
                     done: 1'b0, pass: 1'b0, tmo: 1'b0, fail: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_op_o       = op;
    assign cmd_data_o     = data;
    assign done_o         = s_q.done;
    assign pass_o         = s_q.pass;
    assign poll_timeout_o = s_q.tmo;
    assign hs_fail_o      = s_q.fail;

    p_single_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_one_verdict_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pass_o, poll_timeout_o, hs_fail_o}));

    p_done_has_verdict_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $countones({pass_o, poll_timeout_o, hs_fail_o}) == 1);

    p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == S_IDLE && !start_i && !done_o) |=>
            $stable({pass_o, poll_timeout_o, hs_fail_o}));

    p_try_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.tries < TRW'(MAX_TRIES));

    p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_i && rsp_err_i && s_q.sent) |=> ##1 !cmd_valid_o);

endmodule

// File: tb/sim_phy_rst_seq.sv
module sim_phy_rst_seq;
    localparam int PERIOD = 10;
    localparam int PRE    = 3;
    localparam int POLL   = 5;
    localparam int MAXT   = 4;
    localparam int LAT    = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        cmd_valid_o;
    logic [1:0]  cmd_op_o;
    logic [15:0] cmd_data_o;
    logic        rsp_valid_i = 1'b0;
    logic        rsp_err_i = 1'b0;
    logic [15:0] rsp_data_i = 16'h0;
    logic        done_o, pass_o, poll_timeout_o, hs_fail_o;

    phy_rst_seq #(.PRE_CYCLES(PRE), .POLL_CYCLES(POLL), .MAX_TRIES(MAXT)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o), .cmd_data_o(cmd_data_o),
        .rsp_valid_i(rsp_valid_i), .rsp_err_i(rsp_err_i), .rsp_data_i(rsp_data_i),
        .done_o(done_o), .pass_o(pass_o), .poll_timeout_o(poll_timeout_o),
        .hs_fail_o(hs_fail_o)
    );

    always #(PERIOD/2) clk = ~clk;

    int errors = 0, checks = 0;
    int ncyc = 0, ncmd = 0, nread = 0, ndone = 0;
    int lock_at = 0, err_at = -1;
    int log_op [0:63];
    int log_dat[0:63];
    int log_t  [0:63];
    int rsp_t  [0:63];
    logic [2:0] verdict;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_master();
        int pend = -1;
        int last_op = 0;
        forever begin
            @(negedge clk);
            ncyc++;
            rsp_valid_i = 1'b0;
            rsp_err_i   = 1'b0;
            rsp_data_i  = 16'h0;
            if (pend == 0) begin
                rsp_valid_i = 1'b1;
                rsp_err_i   = (ncmd - 1 == err_at);
                if (last_op == 3)
                    rsp_data_i = (nread == lock_at) ? 16'h0002 : 16'hFFFD;
                rsp_t[ncmd-1] = ncyc;
                pend = -1;
            end else if (pend > 0) begin
                pend--;
            end
            if (cmd_valid_o && ncmd < 64) begin
                log_op[ncmd]  = int'(cmd_op_o);
                log_dat[ncmd] = int'(cmd_data_o);
                log_t[ncmd]   = ncyc;
                last_op = int'(cmd_op_o);
                if (cmd_op_o == 2'd3) nread++;
                ncmd++;
                pend = LAT - 1;
            end
            if (done_o) begin
                ndone++;
                verdict = {pass_o, poll_timeout_o, hs_fail_o};
            end
        end
    endtask

    // lock: read index that reports lock (MAXT+1 = never); err: failing command index
    task automatic run(input int lock, input int err, input bit poke);
        int t0, exp_n, lim;
        logic [2:0] exp_v;
        lock_at = lock; err_at = err;
        ncmd = 0; nread = 0; ndone = 0; verdict = 3'b000;
        @(negedge clk); #1;
        start_i = 1'b1; t0 = ncyc;
        @(negedge clk); #1;
        start_i = 1'b0;
        lim = 0;
        while (ndone == 0 && lim < 2000) begin
            if (poke && ncmd == 3) begin
                start_i = 1'b1;
                @(negedge clk); #1;
                start_i = 1'b0;
                poke = 1'b0;
            end else begin
                @(negedge clk); #1;
            end
            lim++;
        end
        if (lim >= 2000) check(1'b0, "watchdog", lim, 0);
        repeat (6) @(negedge clk);
        #1;

        if (err >= 0) begin exp_n = err + 1; exp_v = 3'b001; end
        else if (lock <= MAXT) begin exp_n = 2 + 2*lock; exp_v = 3'b100; end
        else begin exp_n = 2 + 2*MAXT; exp_v = 3'b010; end

        check(ncmd == exp_n, "R6/R7/R8/R9 command count", ncmd, exp_n);
        check(ndone == 1, "R9/R10 done pulses", ndone, 1);
        check(verdict == exp_v, "R6/R7/R8 verdict at done", int'(verdict), int'(exp_v));
        check({pass_o, poll_timeout_o, hs_fail_o} == exp_v, "R10 verdict held",
              int'({pass_o, poll_timeout_o, hs_fail_o}), int'(exp_v));
        check(log_t[0] - t0 == PRE + 1, "R2 pre-reset delay", log_t[0] - t0, PRE + 1);
        for (int i = 0; i < ncmd; i++) begin
            int eo, ed;
            eo = (i == 0) ? 0 : (i == 1) ? 2 : (i % 2 == 0) ? 0 : 3;
            ed = (i == 0) ? 16'h7F3F : (i == 1) ? 16'h0001 : 16'h2003;
            check(log_op[i] == eo, (i < 2) ? "R3 op" : "R4 op", log_op[i], eo);
            if (eo != 3)
                check(log_dat[i] == ed, (i < 2) ? "R3 data" : "R4 data", log_dat[i], ed);
            if (i >= 2 && i % 2 == 0)
                check(log_t[i] - rsp_t[i-1] == POLL + 1, "R4 poll gap",
                      log_t[i] - rsp_t[i-1], POLL + 1);
            if (i >= 1)
                check(log_t[i] > rsp_t[i-1], "R5 issue after response", log_t[i], rsp_t[i-1]);
        end
    endtask

    initial begin
        fork run_master(); join_none
        repeat (3) @(negedge clk);
        check(!cmd_valid_o && !done_o, "R1 idle outputs", int'({cmd_valid_o, done_o}), 0);
        check({pass_o, poll_timeout_o, hs_fail_o} == 3'b000, "R1 flags",
              int'({pass_o, poll_timeout_o, hs_fail_o}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(ncmd == 0, "R1 no command without start", ncmd, 0);
        for (int n = 1; n <= MAXT + 1; n++) run(n, -1, 1'b0);
        for (int k = 0; k < 6; k++) run(2, k, 1'b0);
        run(2, -1, 1'b1);
        run(MAXT + 1, -1, 1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule